// File: doc/BRIEF.md
# One-Bit Dynamic Memory Access Sequencer

The block connects three internal data streams to an external dynamic RAM of 65,536 words of one bit. The streams are line data, packet data and control data. Each stream presents a 16-bit word address, a direction and a write bit, and holds its request until the block answers. The answer is either a grant or a reject. Each granted request becomes exactly one memory cycle of four clocks at 20.25 MHz. The address goes out as a row half and then a column half on a shared 8-bit bus, using active-low row strobe, column strobe and write enable. A read returns its bit on a shared data output, with a valid strobe for the stream that asked.

Refresh runs in bursts tied to the video line. A line-start pulse loads a burst length. The block then issues that many row-only cycles, each presenting an 8-bit refresh row that advances by one after every cycle and wraps at 256. A window at the top of the address space belongs to host software. Refresh covers it like any other row, but a stream request that points into it is refused with an error pulse and causes no memory activity.

Arbitration happens at slot boundaries: when the sequencer is idle, or in the last clock of a slot. At that point refresh comes before any stream, and the streams rank line, then packet, then control. Slots can run back to back with no idle clock between them.

Top module: `bitram_ctrl`

## Requirements
- R1: While reset is asserted, the row strobe, column strobe and write enable are all high, and no grant, error or read-valid bit is set.
- R2: Each memory cycle, access or refresh, holds the row strobe low for exactly three clocks and then high for one precharge clock.
- R3: In the first clock of an access the address bus carries address bits [15:8] (row). In the remaining three clocks it carries bits [7:0] (column).
- R4: In an access, the column strobe is low in the second and third clocks only. The write enable is low in those same clocks only for a write, and during them the write-data output carries the stream's write bit.
- R5: A read samples the memory data input at the end of its third clock. The bit appears on the read data output with the requesting stream's read-valid bit high for one clock, the fourth clock of the slot, and equals the last bit written to that address.
- R6: When several streams wait at a slot boundary, stream 0 (line) wins over stream 1 (packet), which wins over stream 2 (control). Grant bit i belongs to stream i, and at most one grant bit is high at a time.
- R7: A pending refresh takes the slot ahead of any waiting stream.
- R8: A line-start pulse sets the number of outstanding refreshes to the burst-length input. Each refresh is a row-only cycle with no column strobe, and it presents the refresh row in all four clocks. The row starts at 0 after reset, rises by one after each refresh and wraps from 255 to 0.
- R9: A request whose address is at or above the scratch base (default 0xFF00) gets a one-clock error pulse on its stream's error bit in the clock after the boundary that selected it. No strobe follows for it. An address just below the base is served normally.
- R10: If a stream is waiting when a slot ends, the next slot begins in the very next clock, so grants can come four clocks apart.
- R11: A grant is a one-clock pulse in the first clock of the granted slot, the clock in which the row strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20.25 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-clock pulse at the start of each video line |
| refresh_len | input | 4 | Number of refresh cycles per line burst |
| req_valid | input | 3 | Request pending, one bit per stream (0 line, 1 packet, 2 control) |
| req_write | input | 3 | 1 = write, 0 = read, per stream |
| req_wdata | input | 3 | Write bit per stream |
| req_addr | input | 48 | Word address per stream, stream i in bits [16i+15:16i] |
| req_grant | output | 3 | One-clock grant pulse per stream |
| req_err | output | 3 | One-clock reject pulse per stream (scratch address) |
| rd_valid | output | 3 | One-clock read-data-valid pulse per stream |
| rd_data | output | 1 | Read data bit |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_dout | output | 1 | Write data to the memory |
| dram_din | input | 1 | Read data from the memory |

## Verification
Counting from the clock edge that samples a waiting request, the grant or error pulse is due one clock later. The row strobe falls in that same clock, the column strobe falls one clock after it, and the read-valid pulse comes three clocks after the grant. The bench model steps at each rising edge exactly as the requirements place these events. Its predictions are compared with the ports one nanosecond after every edge, so every strobe, address and pulse is checked in the clock it is due, not merely some time later. Refresh counts, read-back values and priority order are then checked against the pin activity seen by a behavioural memory in the bench.

// File: rtl/bitram_pkg.sv
package bitram_pkg;

    typedef enum logic [1:0] {
        PH_ROW  = 2'd0,
        PH_COL  = 2'd1,
        PH_CAPT = 2'd2,
        PH_PRE  = 2'd3
    } phase_e;

    localparam int DEF_ADDR_W  = 16;
    localparam int DEF_STREAMS = 3;
    localparam int DEF_CNT_W   = 4;

endpackage

// File: rtl/bitram_arb.sv
module bitram_arb #(
    parameter int NS           = 3,
    parameter int ADDR_W       = 16,
    parameter int SCRATCH_BASE = 'hFF00,
    localparam int SRC_W       = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic [NS-1:0]        pend,
    input  logic [NS*ADDR_W-1:0] addrs,
    output logic                 any,
    output logic [SRC_W-1:0]     sel,
    output logic                 bad
);

    logic [NS-1:0] in_scratch;

    for (genvar g = 0; g < NS; g++) begin : g_scr
        assign in_scratch[g] = (int'(addrs[g*ADDR_W +: ADDR_W]) >= SCRATCH_BASE);
    end

    // lowest index wins: scan from the top so the last hit is the winner
    always_comb begin
        any = 1'b0;
        sel = '0;
        bad = 1'b0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                sel = SRC_W'(i);
                bad = in_scratch[i];
            end
        end
    end

endmodule

// File: rtl/bitram_refresh.sv
module bitram_refresh #(
    parameter int ROW_W = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic [CNT_W-1:0] burst_len,
    input  logic             take,
    input  logic             done,
    output logic             pending,
    output logic [ROW_W-1:0] row
);

    typedef struct packed {
        logic [CNT_W-1:0] left;
        logic [ROW_W-1:0] row;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (done) begin
            rf_d.row = rf_q.row + ROW_W'(1);
        end
        if (line_start) begin
            rf_d.left = burst_len;
        end else if (take && rf_q.left != '0) begin
            rf_d.left = rf_q.left - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign pending = (rf_q.left != '0);
    assign row     = rf_q.row;

endmodule

// File: rtl/bitram_pinmux.sv
module bitram_pinmux
    import bitram_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int ROW_W = ADDR_W / 2
) (
    input  logic              busy,
    input  phase_e            phase,
    input  logic              is_ref,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ROW_W-1:0]  ref_row,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ROW_W-1:0]  mux_addr
);

    logic col_window;

    always_comb begin
        col_window = busy && !is_ref && (phase == PH_COL || phase == PH_CAPT);
        ras_n      = !(busy && phase != PH_PRE);
        cas_n      = !col_window;
        we_n       = !(col_window && is_wr);
        if (!busy) begin
            mux_addr = '0;
        end else if (is_ref) begin
            mux_addr = ref_row;
        end else if (phase == PH_ROW) begin
            mux_addr = addr[ADDR_W-1:ROW_W];
        end else begin
            mux_addr = addr[ROW_W-1:0];
        end
    end

endmodule

// File: rtl/bitram_ctrl.sv
module bitram_ctrl
    import bitram_pkg::*;
#(
    parameter int NS           = DEF_STREAMS,
    parameter int ADDR_W       = DEF_ADDR_W,
    parameter int CNT_W        = DEF_CNT_W,
    parameter int SCRATCH_BASE = 'hFF00,
    localparam int ROW_W       = ADDR_W / 2,
    localparam int SRC_W       = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_start,
    input  logic [CNT_W-1:0]     refresh_len,
    input  logic [NS-1:0]        req_valid,
    input  logic [NS-1:0]        req_write,
    input  logic [NS-1:0]        req_wdata,
    input  logic [NS*ADDR_W-1:0] req_addr,
    output logic [NS-1:0]        req_grant,
    output logic [NS-1:0]        req_err,
    output logic [NS-1:0]        rd_valid,
    output logic                 rd_data,
    output logic                 dram_ras_n,
    output logic                 dram_cas_n,
    output logic                 dram_we_n,
    output logic [ROW_W-1:0]     dram_addr,
    output logic                 dram_dout,
    input  logic                 dram_din
);

    typedef struct packed {
        logic              busy;
        phase_e            phase;
        logic              is_ref;
        logic              is_wr;
        logic [SRC_W-1:0]  src;
        logic [ADDR_W-1:0] addr;
        logic              wdata;
        logic [NS-1:0]     grant;
        logic [NS-1:0]     err;
        logic [NS-1:0]     rdv;
        logic              rdata;
    } seq_t;

    seq_t s_d, s_q;

    logic             arb_any, arb_bad;
    logic [SRC_W-1:0] arb_sel;
    logic [NS-1:0]    pend;
    logic             ref_pending, ref_take, ref_done;
    logic [ROW_W-1:0] ref_row;
    logic             slot_edge;

    // a stream answered in the last clock is not considered again this clock
    assign pend = req_valid & ~s_q.grant & ~s_q.err;

    bitram_arb #(
        .NS(NS), .ADDR_W(ADDR_W), .SCRATCH_BASE(SCRATCH_BASE)
    ) u_arb (
        .pend(pend), .addrs(req_addr),
        .any(arb_any), .sel(arb_sel), .bad(arb_bad)
    );

    bitram_refresh #(
        .ROW_W(ROW_W), .CNT_W(CNT_W)
    ) u_ref (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .burst_len(refresh_len), .take(ref_take), .done(ref_done),
        .pending(ref_pending), .row(ref_row)
    );

    always_comb begin
        s_d       = s_q;
        s_d.grant = '0;
        s_d.err   = '0;
        s_d.rdv   = '0;
        ref_take  = 1'b0;
        ref_done  = s_q.busy && s_q.is_ref && (s_q.phase == PH_PRE);
        slot_edge = !s_q.busy || (s_q.phase == PH_PRE);

        if (s_q.busy) begin
            if (s_q.phase == PH_PRE) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.phase = phase_e'(s_q.phase + 2'd1);
            end
            if (s_q.phase == PH_CAPT && !s_q.is_ref) begin
                s_d.rdv[s_q.src] = !s_q.is_wr;
                if (!s_q.is_wr) begin
                    s_d.rdata = dram_din;
                end
            end
        end

        if (slot_edge) begin
            if (ref_pending) begin
                ref_take   = 1'b1;
                s_d.busy   = 1'b1;
                s_d.phase  = PH_ROW;
                s_d.is_ref = 1'b1;
                s_d.is_wr  = 1'b0;
            end else if (arb_any) begin
                if (arb_bad) begin
                    s_d.err[arb_sel] = 1'b1;
                end else begin
                    s_d.grant[arb_sel] = 1'b1;
                    s_d.busy   = 1'b1;
                    s_d.phase  = PH_ROW;
                    s_d.is_ref = 1'b0;
                    s_d.src    = arb_sel;
                    s_d.is_wr  = req_write[arb_sel];
                    s_d.wdata  = req_wdata[arb_sel];
                    s_d.addr   = req_addr[arb_sel*ADDR_W +: ADDR_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    bitram_pinmux #(.ADDR_W(ADDR_W)) u_pins (
        .busy(s_q.busy), .phase(s_q.phase), .is_ref(s_q.is_ref),
        .is_wr(s_q.is_wr), .addr(s_q.addr), .ref_row(ref_row),
        .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
        .mux_addr(dram_addr)
    );

    assign req_grant = s_q.grant;
    assign req_err   = s_q.err;
    assign rd_valid  = s_q.rdv;
    assign rd_data   = s_q.rdata;
    assign dram_dout = s_q.wdata;

endmodule

// File: rtl/bitram_chk.sv
module bitram_chk #(
    parameter int NS = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic [NS-1:0] grant,
    input logic [NS-1:0] err,
    input logic [NS-1:0] rdv
);

    assert_ras_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n) && $past(!ras_n, 2)) |=> ras_n);

    assert_ras_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |=> !ras_n);

    assert_cas_in_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    assert_we_in_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cas_n);

    assert_rdv_after_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|rdv) |-> ($past(!cas_n) && ras_n && $onehot0(rdv)));

    assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_err_no_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|err) |-> (ras_n && (grant == '0)));

    assert_grant_at_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> $fell(ras_n));

endmodule

bind bitram_ctrl bitram_chk #(.NS(NS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .grant(req_grant), .err(req_err), .rdv(rd_valid)
);

// File: tb/sim_bitram_ctrl.sv
`timescale 1ns/1ps
module sim_bitram_ctrl;

    localparam int BASE = 'hFF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [3:0]  refresh_len = 4'd0;
    logic [2:0]  v = '0, wr = '0, wd = '0;
    logic [47:0] addrs = '0;
    logic [2:0]  grant, err, rdv;
    logic        rd_data, ras_n, cas_n, we_n, dout;
    logic [7:0]  maddr;
    logic        din = 1'b0;

    always #2 clk = ~clk;

    bitram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .refresh_len(refresh_len), .req_valid(v), .req_write(wr),
        .req_wdata(wd), .req_addr(addrs), .req_grant(grant),
        .req_err(err), .rd_valid(rdv), .rd_data(rd_data),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
        .dram_addr(maddr), .dram_dout(dout), .dram_din(din)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // behavioural memory driven from the pins, sampled mid-cycle
    bit mem [int];
    int row_l = 0, col_l = 0, rasf = 0, casf = 0, scratch_hits = 0;
    bit ras_prev = 1, cas_prev = 1;
    always @(negedge clk) begin
        if (!ras_n && ras_prev) begin
            row_l = maddr;
            rasf++;
        end
        if (!cas_n && cas_prev) begin
            int k;
            col_l = maddr;
            casf++;
            k = row_l * 256 + col_l;
            if (k >= BASE) scratch_hits++;
            if (!we_n) mem[k] = dout;
            din = mem.exists(k) ? mem[k] : 1'b0;
        end
        ras_prev = ras_n;
        cas_prev = cas_n;
    end

    // reference model, one step per rising edge
    int mph = -1, msrc = 0, maddr_m = 0, mleft = 0, mrow = 0;
    bit mref = 0, mwr = 0, mwd = 0, mrd = 0;
    bit [2:0] mg = 0, me = 0, mrv = 0;

    function automatic int addr_of(input int i);
        return int'(addrs[i*16 +: 16]);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mph = -1; mleft = 0; mrow = 0; mg = 0; me = 0; mrv = 0; mrd = 0;
            mref = 0; mwr = 0; mwd = 0; msrc = 0; maddr_m = 0;
        end else begin
            bit [2:0] og, oe;
            int nph;
            bit take;
            og = mg; oe = me; take = 0;
            mg = 0; me = 0; mrv = 0;
            if (mph == 2 && !mref && !mwr) begin
                mrv[msrc] = 1;
                mrd = din;
            end
            if (mph == 3 && mref) mrow = (mrow + 1) % 256;
            nph = (mph >= 0 && mph < 3) ? mph + 1 : -1;
            if (mph == -1 || mph == 3) begin
                if (mleft > 0) begin
                    nph = 0; mref = 1; mwr = 0; take = 1;
                end else begin
                    for (int i = 0; i < 3; i++) begin
                        if (v[i] && !og[i] && !oe[i]) begin
                            if (addr_of(i) >= BASE) me[i] = 1;
                            else begin
                                mg[i] = 1; nph = 0; mref = 0; mwr = wr[i];
                                mwd = wd[i]; maddr_m = addr_of(i); msrc = i;
                            end
                            break;
                        end
                    end
                end
            end
            mph = nph;
            if (line_start) mleft = refresh_len;
            else if (take) mleft--;
        end
    end

    // comparison one nanosecond after each edge, plus event logging
    int gq[$], gcyc[$], rsrc[$], rval[$];
    int errs[3] = '{0, 0, 0};
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            bit e_ras, e_cas, e_we;
            int e_addr;
            e_ras  = !(mph >= 0 && mph <= 2);
            e_cas  = !((mph == 1 || mph == 2) && !mref);
            e_we   = !((mph == 1 || mph == 2) && !mref && mwr);
            e_addr = (mph < 0) ? 0 : mref ? mrow : (mph == 0) ? (maddr_m >> 8) : (maddr_m & 255);
            chk(ras_n == e_ras, "R2 row strobe", ras_n, e_ras);
            chk(cas_n == e_cas, "R4 column strobe", cas_n, e_cas);
            chk(we_n == e_we, "R4 write enable", we_n, e_we);
            chk(int'(maddr) == e_addr, mref ? "R8 refresh row" : "R3 address mux", maddr, e_addr);
            if (!e_we) chk(dout == mwd, "R4 write data", dout, mwd);
            chk(grant == mg, "R11 grant timing (R6 R7 R10)", grant, mg);
            chk(err == me, "R9 reject pulse", err, me);
            chk(rdv == mrv, "R5 read valid", rdv, mrv);
            if (|mrv) chk(rd_data == mrd, "R5 read data", rd_data, mrd);
            for (int i = 0; i < 3; i++) begin
                if (grant[i]) begin gq.push_back(i); gcyc.push_back(cyc); end
                if (rdv[i]) begin rsrc.push_back(i); rval.push_back(rd_data); end
                if (err[i]) errs[i]++;
            end
        end
    end

    // requester side: drop a request once it has been answered
    always @(posedge clk) begin
        #1;
        for (int i = 0; i < 3; i++) if (grant[i] || err[i]) v[i] = 1'b0;
    end

    task automatic issue(input int s, input bit w, input int a, input bit d);
        @(negedge clk);
        while (v[s]) @(negedge clk);
        wr[s] = w; wd[s] = d; addrs[s*16 +: 16] = 16'(a); v[s] = 1'b1;
    endtask

    task automatic settle();
        @(negedge clk);
        while (v != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
        chk(grant == 0 && err == 0 && rdv == 0, "R1 pulses in reset", {grant, err, rdv}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // writes then reads back through other streams
        issue(0, 1, 'h1234, 1);
        issue(1, 1, 'h00FF, 1);
        issue(2, 1, 'hABCD, 0);
        settle();
        rsrc.delete(); rval.delete();
        issue(2, 0, 'h1234, 0);
        issue(0, 0, 'h00FF, 0);
        issue(1, 0, 'hABCD, 0);
        settle();
        issue(1, 0, 'h4321, 0);
        settle();
        chk(rsrc.size() == 4, "R5 read count", rsrc.size(), 4);
        if (rsrc.size() == 4) begin
            chk(rsrc[0] == 2 && rval[0] == 1, "R5 readback 1234", rval[0], 1);
            chk(rsrc[1] == 0 && rval[1] == 1, "R5 readback 00FF", rval[1], 1);
            chk(rsrc[2] == 1 && rval[2] == 0, "R5 readback ABCD", rval[2], 0);
            chk(rsrc[3] == 1 && rval[3] == 0, "R5 readback unwritten", rval[3], 0);
        end

        // priority and back-to-back slots
        gq.delete(); gcyc.delete();
        @(negedge clk);
        wr = 3'b000; addrs = {16'h0003, 16'h0002, 16'h0001}; v = 3'b111;
        settle();
        chk(gq.size() == 3, "R6 grant count", gq.size(), 3);
        if (gq.size() == 3) begin
            chk(gq[0] == 0 && gq[1] == 1 && gq[2] == 2, "R6 priority order",
                gq[0] * 100 + gq[1] * 10 + gq[2], 12);
            chk(gcyc[1] - gcyc[0] == 4, "R10 slot spacing", gcyc[1] - gcyc[0], 4);
            chk(gcyc[2] - gcyc[1] == 4, "R10 slot spacing", gcyc[2] - gcyc[1], 4);
        end

        // scratch rejection and the boundary just below it
        begin
            int r0, c0;
            r0 = rasf; c0 = casf;
            issue(1, 1, 'hFF10, 1);
            settle();
            chk(errs[1] == 1, "R9 error pulse count", errs[1], 1);
            chk(rasf == r0 && casf == c0, "R9 no memory cycle", rasf - r0, 0);
            issue(2, 0, 'hFFFF, 0);
            settle();
            chk(errs[2] == 1, "R9 top address rejected", errs[2], 1);
            gq.delete();
            issue(0, 1, 'hFEFF, 1);
            settle();
            chk(gq.size() == 1 && errs[0] == 0, "R9 below base granted", gq.size(), 1);
            chk(scratch_hits == 0, "R9 scratch untouched", scratch_hits, 0);
        end

        // refresh precedence over a waiting stream
        begin
            int r0, c0;
            r0 = rasf; c0 = casf;
            @(negedge clk);
            refresh_len = 4'd3; line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
            wr[0] = 0; addrs[15:0] = 16'h0505; v[0] = 1'b1;
            settle();
            chk((rasf - r0) - (casf - c0) == 3, "R7 refreshes before access",
                (rasf - r0) - (casf - c0), 3);
            chk(casf - c0 == 1, "R7 access after burst", casf - c0, 1);
        end

        // row counter wrap over many bursts
        begin
            int r0, c0;
            r0 = rasf; c0 = casf;
            refresh_len = 4'd15;
            for (int n = 0; n < 20; n++) begin
                @(negedge clk); line_start = 1'b1;
                @(negedge clk); line_start = 1'b0;
                repeat (70) @(negedge clk);
            end
            chk(rasf - r0 == 300 && casf == c0, "R8 refresh count", rasf - r0, 300);
        end

        done_flag = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired: actual hung expected done");
            finish_run();
        end
    end

endmodule